// File: doc/BRIEF.md
# Multiplexer-Gain Scan Sequencer

This block drives the input multiplexer and gain stage of a multichannel analog acquisition front end. Software programs a scan list of up to sixteen entries through a 16-bit register write port. Each entry names a channel, a gain code and whether it closes the scan. A write to the convert strobe register makes the block emit one start pulse together with the channel and gain of the entry under the list pointer. When scanning is enabled, the pointer then moves on. It returns to entry 0 after a flagged entry or after the final slot.

Conversion results come back from the converter on a valid/data pair. They are recoded if two's complement output is selected and queued in a sixteen-deep sample FIFO. Software drains the FIFO through a data read register. A status read reports data available, FIFO overflow and conversion overrun. A clear strobe flushes the FIFO and resets both sticky error flags.

The bus carries one access per cycle. If read and write are raised together, the write is taken and the read is ignored. Read data appears on `bus_rdata` in the cycle after the read, and it holds until the next read.

Top module: `mux_scan_seq`

## Requirements
- R1: After synchronous reset, `conv_start`, `mux_chan`, `mux_gain` and `bus_rdata` are 0, all scan entries are 0, the pointer is 0, the FIFO is empty, all status flags are clear and the command bits are 0.
- R2: A write to address 2 stores the data into the entry under the pointer. Bits [3:0] are the channel, bit 4 is the end-of-scan flag and bits [7:6] are the gain. The pointer does not move.
- R3: A write to address 1 loads the pointer from data bits [3:0], so that later entry writes and conversions use that slot.
- R4: With command bit 3 set (written to address 0), each conversion strobe advances the pointer by one. After an entry whose bit 4 is set, or after entry 15, the pointer goes to 0 instead.
- R5: With command bit 3 clear, conversion strobes leave the pointer unchanged, so every conversion reuses the same entry.
- R6: A write to address 3 raises `conv_start` for exactly the following cycle. In that same cycle `mux_chan` and `mux_gain` show the entry that was under the pointer when the write was made. Both hold until the next strobe.
- R7: A cycle with `adc_valid` high pushes `adc_result` into the FIFO. It is pushed unchanged when command bit 0 is 1, and with bit 11 inverted when command bit 0 is 0.
- R8: A read of address 0 returns the status word. Bit 13 is set while the FIFO holds data, bit 9 is overflow, bit 8 is overrun, and all other bits are 0.
- R9: A push into a full FIFO is dropped and sets the overflow flag, which stays set until a clear. A push in the same cycle as a pop of a full FIFO is accepted.
- R10: A read of address 1 pops and returns the oldest sample. When the FIFO is empty, the read returns the last sample popped (0 after reset) and changes nothing.
- R11: Any write to address 4 empties the FIFO and clears both the overflow and overrun flags. A push in the same cycle is discarded.
- R12: A conversion strobe sets the overrun flag when an earlier strobe has not yet been answered by `adc_valid`, unless `adc_valid` is high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write enable |
| bus_rd | input | 1 | Register read enable |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read |
| conv_start | output | 1 | One-cycle conversion start pulse |
| mux_chan | output | 4 | Channel of the entry in use |
| mux_gain | output | 2 | Gain code of the entry in use |
| adc_valid | input | 1 | Conversion result valid |
| adc_result | input | 12 | Conversion result from the converter |

## Verification
The assertions assume that reset is applied at time zero. They also assume at most one bus access per cycle, so a pop can never coincide with a clear and an entry write can never coincide with a pointer load. The stimulus issues every register access through tasks that raise only one of `bus_wr` or `bus_rd`. The only cases that deliberately overlap the bus with the result input are a clear with `adc_valid`, a convert with `adc_valid` and a pop of a full FIFO with `adc_valid`. These are exactly the corners that R9, R11 and R12 define.

// File: rtl/mux_scan_pkg.sv
// Shared address map, bit positions and strobe bundle for the scan sequencer.
// Assumes a 3-bit word address and a 16-bit data bus.
package mux_scan_pkg;

    // Write-side register selects
    localparam logic [2:0] WA_CMD   = 3'd0;
    localparam logic [2:0] WA_PTR   = 3'd1;
    localparam logic [2:0] WA_ENTRY = 3'd2;
    localparam logic [2:0] WA_CONV  = 3'd3;
    localparam logic [2:0] WA_CLEAR = 3'd4;

    // Read-side register selects
    localparam logic [2:0] RA_STATUS = 3'd0;
    localparam logic [2:0] RA_DATA   = 3'd1;

    // Command bit positions
    localparam int CMD_STRAIGHT_BIT = 0;
    localparam int CMD_SCAN_BIT     = 3;

    // Scan entry field positions (channel field starts at bit 0)
    localparam int ENT_LAST_BIT = 4;
    localparam int ENT_GAIN_LSB = 6;

    // Status bit positions
    localparam int ST_AVAIL_BIT = 13;
    localparam int ST_OVF_BIT   = 9;
    localparam int ST_OVR_BIT   = 8;

    // One-hot strobes decoded from a single bus access
    typedef struct packed {
        logic cmd_we;
        logic ptr_we;
        logic ent_we;
        logic conv;
        logic clear;
        logic pop;
        logic stat_rd;
    } strobe_t;

endpackage

// File: rtl/msq_reg_decode.sv
// Bus access decoder and command register.
// Turns each bus cycle into at most one strobe; a write takes precedence
// over a simultaneous read. Holds the coding and scan-enable command bits.
module msq_reg_decode
    import mux_scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [2:0] bus_addr,
    input  logic       cmd_straight_in,
    input  logic       cmd_scan_in,
    output strobe_t    stb,
    output logic       straight,
    output logic       scan_en
);

    // Decode the current access into a single strobe
    always_comb begin
        stb = '0;
        if (bus_wr) begin
            case (bus_addr)
                WA_CMD:   stb.cmd_we = 1'b1;
                WA_PTR:   stb.ptr_we = 1'b1;
                WA_ENTRY: stb.ent_we = 1'b1;
                WA_CONV:  stb.conv   = 1'b1;
                WA_CLEAR: stb.clear  = 1'b1;
                default:  ;
            endcase
        end else if (bus_rd) begin
            case (bus_addr)
                RA_STATUS: stb.stat_rd = 1'b1;
                RA_DATA:   stb.pop     = 1'b1;
                default:   ;
            endcase
        end
    end

    // Command register: result coding and scan enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            straight <= 1'b0;
            scan_en  <= 1'b0;
        end else if (stb.cmd_we) begin
            straight <= cmd_straight_in;
            scan_en  <= cmd_scan_in;
        end
    end

endmodule

// File: rtl/msq_scan_list.sv
// Scan-list storage, list pointer and multiplexer outputs.
// Each entry packs {last, gain, channel}. The pointer selects the entry that
// an entry write lands in and the entry a conversion uses. Assumes entry
// writes, pointer loads and conversions never coincide (one bus access/cycle).
module msq_scan_list #(
    parameter int N_ENTRIES = 16,
    parameter int CHAN_W    = 4,
    parameter int GAIN_W    = 2,
    localparam int PTR_W    = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_we,
    input  logic [PTR_W-1:0]  ptr_val,
    input  logic              ent_we,
    input  logic [CHAN_W-1:0] ent_chan,
    input  logic [GAIN_W-1:0] ent_gain,
    input  logic              ent_last,
    input  logic              conv,
    input  logic              scan_en,
    output logic [PTR_W-1:0]  cur_ptr,
    output logic              conv_start,
    output logic [CHAN_W-1:0] chan,
    output logic [GAIN_W-1:0] gain
);

    localparam int ENT_W = CHAN_W + GAIN_W + 1;
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(N_ENTRIES - 1);

    logic [N_ENTRIES*ENT_W-1:0] table_flat;
    logic [ENT_W-1:0]           sel_ent;
    logic [CHAN_W-1:0]          sel_chan;
    logic [GAIN_W-1:0]          sel_gain;
    logic                       sel_last;
    logic [PTR_W-1:0]           ptr_q;

    // One storage word per entry
    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
        logic [ENT_W-1:0] word_q;

        // Capture an entry write addressed to this slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (ent_we && (ptr_q == PTR_W'(e))) begin
                word_q <= {ent_last, ent_gain, ent_chan};
            end
        end

        assign table_flat[e*ENT_W +: ENT_W] = word_q;
    end

    // Select the entry under the pointer
    always_comb begin
        sel_ent  = table_flat[ptr_q*ENT_W +: ENT_W];
        sel_chan = sel_ent[CHAN_W-1:0];
        sel_gain = sel_ent[CHAN_W +: GAIN_W];
        sel_last = sel_ent[ENT_W-1];
    end

    // Pointer: software load, or advance/wrap on a scanning conversion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ptr_we) begin
            ptr_q <= ptr_val;
        end else if (conv && scan_en) begin
            if (sel_last || (ptr_q == LAST_SLOT)) begin
                ptr_q <= '0;
            end else begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    // Start pulse and multiplexer settings for the strobed entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_start <= 1'b0;
            chan       <= '0;
            gain       <= '0;
        end else begin
            conv_start <= conv;
            if (conv) begin
                chan <= sel_chan;
                gain <= sel_gain;
            end
        end
    end

    assign cur_ptr = ptr_q;

endmodule

// File: rtl/msq_sample_fifo.sv
// Sample FIFO with sticky overflow flag.
// A clear wins over a push in the same cycle. A push into a full FIFO is
// accepted only when a pop frees a slot in that cycle; otherwise it is
// dropped and flags overflow. Assumes pop and clear never coincide.
module msq_sample_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 12,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic          clear,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full,
    output logic          overflow
);

    localparam logic [AW-1:0]    TOP_IDX = AW'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DW-1:0]    store [DEPTH];
    logic [AW-1:0]    wr_idx, rd_idx;
    logic [CNT_W-1:0] count;
    logic             pop_ok, push_ok, push_drop;

    // Qualify the requests against occupancy and clear
    always_comb begin
        pop_ok    = pop && !empty && !clear;
        push_ok   = push && !clear && (!full || pop_ok);
        push_drop = push && !clear && full && !pop_ok;
    end

    // Sample storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                store[i] <= '0;
            end
        end else if (push_ok) begin
            store[wr_idx] <= push_data;
        end
    end

    // Indices and occupancy count
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_idx <= (wr_idx == TOP_IDX) ? '0 : wr_idx + 1'b1;
            end
            if (pop_ok) begin
                rd_idx <= (rd_idx == TOP_IDX) ? '0 : rd_idx + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    // Sticky overflow, released only by clear
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            overflow <= 1'b0;
        end else if (push_drop) begin
            overflow <= 1'b1;
        end
    end

    assign head  = store[rd_idx];
    assign empty = (count == '0);
    assign full  = (count == FULL_CNT);

endmodule

// File: rtl/mux_scan_seq.sv
// Multiplexer-gain scan sequencer top.
// Joins the bus decoder, scan list and sample FIFO. It adds result recoding,
// overrun tracking and the registered read-data path. Assumes CHAN_W <= 4,
// so that the channel field stays below the end-of-scan bit.
module mux_scan_seq
    import mux_scan_pkg::*;
#(
    parameter int N_ENTRIES  = 16,
    parameter int CHAN_W     = 4,
    parameter int GAIN_W     = 2,
    parameter int FIFO_DEPTH = 16,
    parameter int ADC_W      = 12,
    parameter int BUS_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              conv_start,
    output logic [CHAN_W-1:0] mux_chan,
    output logic [GAIN_W-1:0] mux_gain,
    input  logic              adc_valid,
    input  logic [ADC_W-1:0]  adc_result
);

    localparam int PTR_W = $clog2(N_ENTRIES);

    strobe_t          stb;
    logic             straight, scan_en;
    logic [PTR_W-1:0] cur_ptr;
    logic [ADC_W-1:0] coded, fifo_head, last_pop;
    logic             fifo_empty, fifo_full, fifo_ovf;
    logic             pending_q, ovr_q;
    logic [BUS_W-1:0] status_word;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata;

    msq_reg_decode u_dec (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_wr          (bus_wr),
        .bus_rd          (bus_rd),
        .bus_addr        (bus_addr),
        .cmd_straight_in (bus_wdata[CMD_STRAIGHT_BIT]),
        .cmd_scan_in     (bus_wdata[CMD_SCAN_BIT]),
        .stb             (stb),
        .straight        (straight),
        .scan_en         (scan_en)
    );

    msq_scan_list #(
        .N_ENTRIES (N_ENTRIES),
        .CHAN_W    (CHAN_W),
        .GAIN_W    (GAIN_W)
    ) u_list (
        .clk        (clk),
        .rst_n      (rst_n),
        .ptr_we     (stb.ptr_we),
        .ptr_val    (bus_wdata[PTR_W-1:0]),
        .ent_we     (stb.ent_we),
        .ent_chan   (bus_wdata[CHAN_W-1:0]),
        .ent_gain   (bus_wdata[ENT_GAIN_LSB +: GAIN_W]),
        .ent_last   (bus_wdata[ENT_LAST_BIT]),
        .conv       (stb.conv),
        .scan_en    (scan_en),
        .cur_ptr    (cur_ptr),
        .conv_start (conv_start),
        .chan       (mux_chan),
        .gain       (mux_gain)
    );

    // Recode the result: invert the top bit for two's complement output
    always_comb begin
        coded = adc_result;
        if (!straight) begin
            coded[ADC_W-1] = ~adc_result[ADC_W-1];
        end
    end

    msq_sample_fifo #(
        .DEPTH (FIFO_DEPTH),
        .DW    (ADC_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (adc_valid),
        .push_data (coded),
        .pop       (stb.pop),
        .clear     (stb.clear),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .overflow  (fifo_ovf)
    );

    // Track an outstanding conversion and flag a strobe that outruns it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            ovr_q     <= 1'b0;
        end else begin
            if (stb.conv) begin
                pending_q <= 1'b1;
            end else if (adc_valid) begin
                pending_q <= 1'b0;
            end
            if (stb.clear) begin
                ovr_q <= 1'b0;
            end else if (stb.conv && pending_q && !adc_valid) begin
                ovr_q <= 1'b1;
            end
        end
    end

    // Assemble the status word
    always_comb begin
        status_word               = '0;
        status_word[ST_AVAIL_BIT] = !fifo_empty;
        status_word[ST_OVF_BIT]   = fifo_ovf;
        status_word[ST_OVR_BIT]   = ovr_q;
    end

    // Remember the most recently popped sample for empty reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_pop <= '0;
        end else if (stb.pop && !fifo_empty) begin
            last_pop <= fifo_head;
        end
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (stb.stat_rd) begin
            bus_rdata <= status_word;
        end else if (stb.pop) begin
            bus_rdata <= BUS_W'(fifo_empty ? last_pop : fifo_head);
        end else if (bus_rd && !bus_wr) begin
            bus_rdata <= '0;
        end
    end

endmodule

// File: rtl/msq_checker.sv
// Temporal checks on the scan sequencer, bound to every mux_scan_seq instance.
// Assumes reset is asserted from time zero.
module msq_checker #(
    parameter int PTR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_stb,
    input logic             conv_start,
    input logic             ptr_we,
    input logic             scan_en,
    input logic [PTR_W-1:0] cur_ptr,
    input logic             clr_stb,
    input logic             pop_stb,
    input logic             push,
    input logic             fifo_empty,
    input logic             fifo_ovf,
    input logic             ovr
);

    // R6
    conv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_stb |=> conv_start);

    // R6
    conv_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(conv_stb));

    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && !ptr_we) |=> $stable(cur_ptr));

    // R11
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> (fifo_empty && !fifo_ovf && !ovr));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_ovf && !clr_stb) |=> fifo_ovf);

    // R10
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_stb && fifo_empty && !push) |=> fifo_empty);

endmodule

bind mux_scan_seq msq_checker #(
    .PTR_W (PTR_W)
) u_msq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_stb   (stb.conv),
    .conv_start (conv_start),
    .ptr_we     (stb.ptr_we),
    .scan_en    (scan_en),
    .cur_ptr    (cur_ptr),
    .clr_stb    (stb.clear),
    .pop_stb    (stb.pop),
    .push       (adc_valid),
    .fifo_empty (fifo_empty),
    .fifo_ovf   (fifo_ovf),
    .ovr        (ovr_q)
);

// File: tb/mux_scan_seq_bench.sv
// Bench for mux_scan_seq: a behavioural reference model compared every
// clock, plus directed checks with hand-derived values.
module mux_scan_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        conv_start;
    logic [3:0]  mux_chan;
    logic [1:0]  mux_gain;
    logic        adc_valid = 1'b0;
    logic [11:0] adc_result = '0;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cyc     = 0;
    string cur_req = "R1";

    mux_scan_seq u_mux_scan_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .conv_start (conv_start),
        .mux_chan   (mux_chan),
        .mux_gain   (mux_gain),
        .adc_valid  (adc_valid),
        .adc_result (adc_result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state
    int m_mem [16];
    int m_ptr;
    bit m_straight, m_scan, m_ovf, m_ovr, m_pend;
    int m_q [$];
    int m_last;
    int e_rd, e_start, e_chan, e_gain;
    bit started = 1'b0;

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural model, updated on each rising edge from pre-edge values
    always @(posedge clk) begin : model
        int st;
        int cur;
        bit rd;
        started = 1'b1;
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_ptr = 0; m_straight = 0; m_scan = 0;
            m_ovf = 0; m_ovr = 0; m_pend = 0; m_last = 0;
            m_q.delete();
            e_rd = 0; e_start = 0; e_chan = 0; e_gain = 0;
        end else begin
            rd = bus_rd && !bus_wr;
            st = (m_q.size() > 0 ? 'h2000 : 0) | (m_ovf ? 'h200 : 0) | (m_ovr ? 'h100 : 0);
            e_start = 0;
            if (rd) begin
                if (bus_addr == 0) e_rd = st;
                else if (bus_addr == 1) begin
                    if (m_q.size() > 0) m_last = m_q.pop_front();
                    e_rd = m_last;
                end else e_rd = 0;
            end
            if (bus_wr && bus_addr == 4) begin
                m_q.delete(); m_ovf = 0; m_ovr = 0;
            end else if (adc_valid) begin
                if (m_q.size() < 16) m_q.push_back(m_straight ? int'(adc_result) : (int'(adc_result) ^ 'h800));
                else m_ovf = 1;
            end
            if (bus_wr && bus_addr == 3) begin
                if (m_pend && !adc_valid) m_ovr = 1;
                m_pend = 1;
                e_start = 1;
                cur = m_mem[m_ptr];
                e_chan = cur & 15;
                e_gain = (cur >> 6) & 3;
                if (m_scan) m_ptr = (((cur >> 4) & 1) == 1 || m_ptr == 15) ? 0 : m_ptr + 1;
            end else if (adc_valid) m_pend = 0;
            if (bus_wr && bus_addr == 1) m_ptr = int'(bus_wdata) & 15;
            if (bus_wr && bus_addr == 2) m_mem[m_ptr] = int'(bus_wdata);
            if (bus_wr && bus_addr == 0) begin
                m_straight = bus_wdata[0];
                m_scan     = bus_wdata[3];
            end
        end
    end

    // Compare every output against the model away from the active edge
    always @(negedge clk) begin
        if (started) begin
            chk("R6 conv_start vs model", int'(conv_start), e_start);
            chk("R2 mux_chan vs model", int'(mux_chan), e_chan);
            chk("R2 mux_gain vs model", int'(mux_gain), e_gain);
            chk({cur_req, " bus_rdata vs model"}, int'(bus_rdata), e_rd);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_exp(input logic [2:0] a, input int exp, input string tag);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(tag, int'(bus_rdata), exp);
    endtask

    task automatic adc(input logic [11:0] v);
        adc_valid = 1'b1; adc_result = v;
        @(negedge clk);
        adc_valid = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R1";
        chk("R1 conv_start after reset", int'(conv_start), 0);
        rd_exp(0, 0, "R1 status after reset");
        rd_exp(1, 0, "R1 empty data after reset");

        cur_req = "R3";
        wr(1, 0);  wr(2, 16'h0085);
        wr(1, 1);  wr(2, 16'h0059);
        wr(1, 2);  wr(2, 16'h00C3);
        wr(1, 2);  wr(3, 0);
        chk("R3 pointer selects entry 2 chan", int'(mux_chan), 3);
        chk("R2 gain field bits 7:6", int'(mux_gain), 3);
        adc(0);

        cur_req = "R5";
        wr(1, 0);
        wr(3, 0); chk("R5 first conv chan", int'(mux_chan), 5);
        chk("R2 entry 0 gain", int'(mux_gain), 2);
        adc(1);
        wr(3, 0); chk("R5 pointer held chan", int'(mux_chan), 5);
        adc(2);
        wr(4, 0);

        cur_req = "R4";
        wr(0, 16'h0009);
        wr(1, 0);
        for (int i = 0; i < 4; i++) begin
            wr(3, 0);
            chk("R4 scan order", int'(mux_chan), (i % 2 == 0) ? 5 : 9);
            adc(12'(i));
        end
        wr(1, 14); wr(2, 16'h000A);
        wr(1, 15); wr(2, 16'h0007);
        wr(1, 14);
        wr(3, 0); chk("R4 entry 14", int'(mux_chan), 10); adc(0);
        wr(3, 0); chk("R4 entry 15", int'(mux_chan), 7);  adc(0);
        wr(3, 0); chk("R4 wrap after slot 15", int'(mux_chan), 5); adc(0);
        wr(4, 0);

        cur_req = "R7";
        adc(12'h123);
        rd_exp(1, 'h123, "R7 straight coding");
        wr(0, 0);
        adc(12'h123);
        rd_exp(1, 'h923, "R7 twos complement coding");
        adc(12'hFFF);
        rd_exp(1, 'h7FF, "R7 twos complement top bit");

        cur_req = "R10";
        rd_exp(1, 'h7FF, "R10 empty read returns last");
        rd_exp(1, 'h7FF, "R10 empty read repeated");
        rd_exp(0, 0, "R10 status unchanged by empty read");

        cur_req = "R8";
        adc(12'h001);
        rd_exp(0, 'h2000, "R8 available bit");
        rd_exp(1, 'h801, "R8 pop value");
        rd_exp(0, 0, "R8 available cleared");

        cur_req = "R9";
        for (int i = 0; i < 17; i++) adc(12'(i));
        rd_exp(0, 'h2200, "R9 overflow on full push");
        rd_exp(1, 'h800, "R9 oldest first");
        for (int i = 1; i < 15; i++) rd_exp(1, i ^ 'h800, "R9 in-order drain");
        rd_exp(1, 'h80F, "R9 sixteenth kept");
        rd_exp(1, 'h80F, "R9 seventeenth dropped");
        rd_exp(0, 'h0200, "R9 overflow sticky");

        cur_req = "R11";
        wr(4, 0);
        rd_exp(0, 0, "R11 clear drops overflow");
        for (int i = 0; i < 16; i++) adc(12'(i + 16));
        cur_req = "R9";
        bus_rd = 1'b1; bus_addr = 1; adc_valid = 1'b1; adc_result = 12'h055;
        @(negedge clk);
        bus_rd = 1'b0; adc_valid = 1'b0;
        chk("R9 pop while full", int'(bus_rdata), 'h810);
        rd_exp(0, 'h2000, "R9 push accepted with pop");

        cur_req = "R11";
        wr(4, 0);
        rd_exp(0, 0, "R11 clear empties");
        bus_wr = 1'b1; bus_addr = 4; adc_valid = 1'b1; adc_result = 12'h321;
        @(negedge clk);
        bus_wr = 1'b0; adc_valid = 1'b0;
        rd_exp(0, 0, "R11 same-cycle push dropped");

        cur_req = "R12";
        wr(1, 0);
        wr(3, 0);
        wr(3, 0);
        rd_exp(0, 'h0100, "R12 overrun on unanswered strobe");
        wr(4, 0);
        rd_exp(0, 0, "R11 clear drops overrun");
        bus_wr = 1'b1; bus_addr = 3; adc_valid = 1'b1; adc_result = 12'h400;
        @(negedge clk);
        bus_wr = 1'b0; adc_valid = 1'b0;
        rd_exp(0, 'h2000, "R12 no overrun when result coincides");

        cur_req = "R6";
        adc(0);
        wr(4, 0);
        wr(3, 0);
        chk("R6 start pulse", int'(conv_start), 1);
        @(negedge clk);
        chk("R6 pulse one cycle", int'(conv_start), 0);
        adc(0);
        repeat (2) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule